// File: doc/BRIEF.md
# Code-Selected Reference Frequency Divider

This block divides a reference clock by one of eight fixed ratios and emits a single-cycle strobe once per divided period. The strobe is meant to feed a phase comparator as its reference edge. The ratio is not loaded as a binary number. A 3-bit selection code indexes a small decode table, and the table supplies the reload value for a 14-bit down-counter.

The ratios are mostly powers of two. Code 000 gives the smallest ratio. Codes 001 through 111 double the ratio at each step, from 128 up to 8192. Board-level pull-ups leave an unconnected selection reading all ones, so code 111 (divide by 8192) is the default. The block samples the selection code only at the terminal count. A code that changes in the middle of a period therefore never cuts that period short. A parameter can move the code-000 entry down to divide-by-1, in which case the strobe is high on every cycle.

Top module: `refdiv_top`

## Requirements
- R1: While `rst_n` is low, `ref_strobe` is low and the counter is loaded from the currently selected ratio. After `rst_n` rises, the first strobe appears in the Nth cycle, where N is the selected ratio.
- R2: Selection codes 000, 001, 010, 011, 100 and 101 give periods of 8, 128, 256, 512, 1024 and 2048 reference cycles.
- R3: Code 110 gives a period of 4096 cycles. Code 111, which is the default, gives a period of 8192 cycles.
- R4: `ref_strobe` stays high for exactly one cycle and then stays low for the remaining N-1 cycles of each period.
- R5: A new selection code takes effect only at the next terminal count. The period that is running finishes at the old ratio, and the following period uses the new ratio.
- R6: The counter counts down by one on each cycle. On reaching zero it reloads with (ratio - 1), and the strobe follows one cycle later.
- R7: With the code-000 table entry configured as log2 ratio 0, code 000 divides by 1: `ref_strobe` is high on every cycle after reset.
- R8: A selection code that changes and then returns to its original value before the terminal count has no effect on the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| ratio_sel | input | 3 | Ratio selection code |
| ref_strobe | output | 1 | One-cycle strobe per divided period |

## Verification
On every cycle, the assertions check four things: the count decrements by one between terminal counts, the counter reloads from the decoder at zero, the strobe mirrors the terminal-count event one cycle later and is forced low in reset, and the decoder output always has the form 2^k - 1. Several behaviours appear only across whole periods, so only the bench's directed scenarios can show them. These are the absolute period for each code, the delay from reset release to the first strobe, the deferral of a mid-period code change, and the strobe held high in divide-by-1.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  // log2 of the divide ratio for a given selection code
  function automatic int unsigned ratio_log2(input int unsigned code,
                                             input int unsigned code0_log2,
                                             input int unsigned base_log2);
    return (code == 0) ? code0_log2 : code + base_log2;
  endfunction

  // counter reload value (ratio - 1) for a given log2 ratio
  function automatic logic [31:0] reload_of(input int unsigned lg);
    return (32'd1 << lg) - 32'd1;
  endfunction

endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode #(
  parameter int SEL_W      = 3,
  parameter int CNT_W      = 14,
  parameter int CODE0_LOG2 = 3,
  parameter int BASE_LOG2  = 6
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] reload
);
  import refdiv_pkg::*;

  localparam int DEPTH = 1 << SEL_W;

  logic [CNT_W-1:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [31:0] RV =
      reload_of(ratio_log2(g, CODE0_LOG2, BASE_LOG2));
    assign table_w[g] = RV[CNT_W-1:0];
  end

  assign reload = table_w[sel];
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             tc
);
  assign tc = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= reload;
    else if (tc) cnt <= reload;
    else         cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/refdiv_pulse.sv
module refdiv_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic tc,
  output logic strobe
);
  always_ff @(posedge clk) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= tc;
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
  parameter int SEL_W      = 3,
  parameter int CNT_W      = 14,
  parameter int CODE0_LOG2 = 3,
  parameter int BASE_LOG2  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             ref_strobe
);
  // named internal events, brought out for the checker
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] count_q;
  logic             term_evt;

  refdiv_decode #(
    .SEL_W(SEL_W), .CNT_W(CNT_W),
    .CODE0_LOG2(CODE0_LOG2), .BASE_LOG2(BASE_LOG2)
  ) u_decode (
    .sel(ratio_sel), .reload(reload_val)
  );

  refdiv_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .reload(reload_val),
    .cnt(count_q), .tc(term_evt)
  );

  refdiv_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .tc(term_evt), .strobe(ref_strobe)
  );
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] reload_val,
  input logic [CNT_W-1:0] count_q,
  input logic             term_evt,
  input logic             ref_strobe
);
  logic [CNT_W:0] reload_p1;
  assign reload_p1 = {1'b0, reload_val} + (CNT_W+1)'(1);

  // R1: strobe held low through reset
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |=> !ref_strobe);

  // R4: strobe follows terminal count one cycle later
  p_strobe_on_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> ref_strobe);
  p_strobe_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !term_evt |=> !ref_strobe);

  // R6: decrement between terminal counts, reload at zero
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !term_evt |=> count_q == $past(count_q) - CNT_W'(1));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> count_q == $past(reload_val));

  // R2: every decoded ratio is a power of two
  p_pow2_ratio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reload_p1) == 1);
endmodule

bind refdiv_top refdiv_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reload_val(reload_val),
  .count_q(count_q), .term_evt(term_evt), .ref_strobe(ref_strobe)
);

// File: tb/refdiv_top_test.sv
module refdiv_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b111;
  logic [2:0] sel1 = 3'b000;
  logic       strobe, strobe1;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  refdiv_top uut (.clk(clk), .rst_n(rst_n), .ratio_sel(sel), .ref_strobe(strobe));
  refdiv_top #(.CODE0_LOG2(0)) uut_div1 (.clk(clk), .rst_n(rst_n),
    .ratio_sel(sel1), .ref_strobe(strobe1));

  function automatic int exp_ratio(input int code);
    if (code == 0) return 8;
    return 1 << (code + 6);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges until strobe is seen high
  task automatic wait_strobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!strobe && n < 20000);
  endtask

  task automatic do_reset(input logic [2:0] code);
    @(negedge clk);
    rst_n = 1'b0;
    sel = code;
    repeat (3) begin
      @(negedge clk);
      check(strobe == 1'b0, "R1 strobe low in reset", strobe, 0);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_code(input int code, input string req);
    int n;
    do_reset(code[2:0]);
    wait_strobe(n);
    check(n == exp_ratio(code), "R1 first strobe delay", n, exp_ratio(code));
    @(negedge clk);
    check(strobe == 1'b0, "R4 strobe width one cycle", strobe, 0);
    n = 1;
    while (!strobe && n < 20000) begin @(negedge clk); n++; end
    check(n == exp_ratio(code), {req, " R6 period"}, n, exp_ratio(code));
  endtask

  task automatic t_switch;
    int n;
    do_reset(3'b001);
    wait_strobe(n);
    repeat (10) @(negedge clk);
    sel = 3'b000;
    n = 10;
    while (!strobe && n < 20000) begin @(negedge clk); n++; end
    check(n == 128, "R5 old period completes", n, 128);
    wait_strobe(n);
    check(n == 8, "R5 new ratio after tc", n, 8);
  endtask

  task automatic t_glitch;
    int n;
    do_reset(3'b000);
    wait_strobe(n);
    @(negedge clk); sel = 3'b111;
    repeat (3) @(negedge clk);
    sel = 3'b000;
    n = 4;
    while (!strobe && n < 20000) begin @(negedge clk); n++; end
    check(n == 8, "R8 transient code ignored", n, 8);
  endtask

  task automatic t_div1;
    do_reset(3'b111);
    check(strobe1 == 1'b0, "R7 div1 low in reset", strobe1, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(strobe1 == 1'b1, "R7 div1 strobe every cycle", strobe1, 1);
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(strobe == 1'b0, "R1 reset state", strobe, 0);
    for (int c = 0; c < 6; c++) t_code(c, "R2");
    t_code(6, "R3");
    t_code(7, "R3");
    t_switch();
    t_glitch();
    t_div1();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule